// File: doc/BRIEF.md
# Dual-Section Parity Bus Transceiver

This block is a 16-bit two-way bus transceiver built as two independent 8-bit sections. For each section a direction input picks which way data moves. In transmit it copies the A-side byte to the B side. In receive it copies the B-side byte to the A side. A high-impedance input turns off both data sides of a section.

Each section has one parity pin, and its role follows the direction. In transmit the section drives that pin with a generated bit, so that the nine bits (data plus parity) meet the selected odd or even sense. In receive the pin is an input. The section checks the B-side byte together with the received bit and pulls an active-low error flag low when the sense is broken.

Every pad is split into an input value, an output value and an active-high drive enable, so that the block can be synthesized. The logic is purely combinational.

Top module: `pxc_wide_xcvr`

## Requirements
- R1: The two sections are independent. Section s uses bits [8s+7:8s] of the data buses and bit s of every per-section signal, and the inputs of one section never change the outputs of the other.
- R2: With `dir_i`=1 (transmit) and `hiz_i`=0, `b_oe` is 1 and `a_oe` is 0. `b_o` always carries `a_i` bit for bit, with no inversion.
- R3: With `dir_i`=0 (receive) and `hiz_i`=0, `a_oe` is 1 and `b_oe` is 0. `a_o` always carries `b_i` bit for bit, with no inversion.
- R4: With `hiz_i`=1, both `a_oe` and `b_oe` are 0 for that section, whatever the direction.
- R5: `par_o` is the bit that makes the count of ones in the A byte plus `par_o` even when `odd_i`=0 and odd when `odd_i`=1. `par_oe` is 1 only in transmit with `hiz_i`=0.
- R6: In receive with `hiz_i`=0, `err_n_o` is 0 exactly when the count of ones in the B byte plus `par_i` breaks the selected sense (odd when `odd_i`=0, even when `odd_i`=1), and 1 otherwise.
- R7: In transmit, or with `hiz_i`=1, `err_n_o` is held at 1.
- R8: All outputs follow their inputs combinationally, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dir_i | input | 2 | Per-section direction, 1 = transmit A to B, 0 = receive B to A |
| hiz_i | input | 2 | Per-section disable, 1 = both data sides undriven |
| odd_i | input | 2 | Per-section parity sense, 1 = odd, 0 = even |
| a_i | input | 16 | A-side pad input values |
| a_o | output | 16 | A-side pad output values |
| a_oe | output | 2 | A-side drive enable per section |
| b_i | input | 16 | B-side pad input values |
| b_o | output | 16 | B-side pad output values |
| b_oe | output | 2 | B-side drive enable per section |
| par_i | input | 2 | Parity pad input value per section |
| par_o | output | 2 | Generated parity per section |
| par_oe | output | 2 | Parity pad drive enable per section |
| err_n_o | output | 2 | Active-low parity error per section |

## Verification
The bench aims at the sense of parity. A generator that has even and odd swapped gives the wrong bit on every byte, and the bench catches this with a byte of five ones under even sense. A checker that does not fold in the received parity bit misses the error on three ones plus a set parity bit under odd sense. The bench also toggles one section while it holds the other still, which exposes crossed slice indices or shared control lines. It sweeps the disable input in both directions to find a drive enable or error flag that leaks through while the section is undriven.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dir_e;

    typedef struct packed {
        logic hiz;
        dir_e dir;
        logic odd_sel;
    } sec_ctl_t;

    typedef struct packed {
        logic a_drv;
        logic b_drv;
        logic p_drv;
    } drv_t;

    // Which pads a section drives for a given control setting.
    function automatic drv_t decode_drv(input sec_ctl_t c);
        drv_t d;
        d.a_drv = !c.hiz && (c.dir == DIR_RX);
        d.b_drv = !c.hiz && (c.dir == DIR_TX);
        d.p_drv = d.b_drv;
        return d;
    endfunction

    // Loop-based odd-count test, used by assertions as an independent path.
    function automatic logic count_is_odd(input logic [63:0] v, input int unsigned w);
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < 64; i++) begin
            if (i < int'(w)) acc = acc ^ v[i];
        end
        return acc;
    endfunction

endpackage

// File: rtl/pxc_xor_tree.sv
module pxc_xor_tree #(
    parameter int W = 8
) (
    input  logic [W-1:0] vec_i,
    output logic         odd_o
);
    localparam int LVL = (W > 1) ? $clog2(W) : 0;
    localparam int P   = 1 << LVL;

    logic [2*P-1:0] node;

    // Heap layout: leaves at P..2P-1, root at index 1, zero-padded leaves.
    generate
        for (genvar i = 0; i < P; i++) begin : g_leaf
            if (i < W) begin : g_real
                assign node[P+i] = vec_i[i];
            end else begin : g_pad
                assign node[P+i] = 1'b0;
            end
        end
        for (genvar j = 1; j < P; j++) begin : g_inner
            assign node[j] = node[2*j] ^ node[2*j+1];
        end
    endgenerate

    assign node[0] = 1'b0;
    assign odd_o   = node[1];

endmodule

// File: rtl/pxc_steer.sv
module pxc_steer
    import pxc_pkg::*;
#(
    parameter int W = 8
) (
    input  sec_ctl_t     ctl_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o,
    output drv_t         drv_o
);
    always_comb begin
        drv_o = decode_drv(ctl_i);
        a_o   = b_i;
        b_o   = a_i;
    end

    always_comb begin
        if (!$isunknown(ctl_i)) begin
            assert_one_side_R4: assert (!(drv_o.a_drv && drv_o.b_drv))
                else $error("both data sides driven");
            if (ctl_i.hiz) begin
                assert_hiz_quiet_R4: assert (!drv_o.a_drv && !drv_o.b_drv && !drv_o.p_drv)
                    else $error("drive while disabled");
            end
        end
    end

endmodule

// File: rtl/pxc_parity_unit.sv
module pxc_parity_unit
    import pxc_pkg::*;
#(
    parameter int W = 8
) (
    input  sec_ctl_t     ctl_i,
    input  logic [W-1:0] gen_src_i,
    input  logic [W-1:0] chk_src_i,
    input  logic         par_i,
    output logic         par_o,
    output logic         err_n_o
);
    logic gen_odd;
    logic chk_odd;
    logic total_odd;
    logic check_live;

    pxc_xor_tree #(.W(W)) u_gen_tree (.vec_i(gen_src_i), .odd_o(gen_odd));
    pxc_xor_tree #(.W(W)) u_chk_tree (.vec_i(chk_src_i), .odd_o(chk_odd));

    always_comb begin
        par_o      = gen_odd ^ ctl_i.odd_sel;
        total_odd  = chk_odd ^ par_i;
        check_live = !ctl_i.hiz && (ctl_i.dir == DIR_RX);
        err_n_o    = check_live ? (total_odd == ctl_i.odd_sel) : 1'b1;
    end

    always_comb begin
        if (!$isunknown({ctl_i, gen_src_i, chk_src_i, par_i})) begin
            assert_gen_sense_R5: assert ((count_is_odd(64'(gen_src_i), W) ^ par_o) == ctl_i.odd_sel)
                else $error("generated parity has wrong sense");
            if (!ctl_i.hiz && ctl_i.dir == DIR_RX) begin
                assert_chk_sense_R6: assert (err_n_o ==
                        ((count_is_odd(64'(chk_src_i), W) ^ par_i) == ctl_i.odd_sel))
                    else $error("checker flag disagrees");
            end else begin
                assert_err_idle_R7: assert (err_n_o)
                    else $error("error flag active outside receive");
            end
        end
    end

endmodule

// File: rtl/pxc_section.sv
module pxc_section
    import pxc_pkg::*;
#(
    parameter int W = 8
) (
    input  sec_ctl_t     ctl_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         par_i,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o,
    output drv_t         drv_o,
    output logic         par_o,
    output logic         err_n_o
);
    pxc_steer #(.W(W)) u_steer (
        .ctl_i (ctl_i),
        .a_i   (a_i),
        .b_i   (b_i),
        .a_o   (a_o),
        .b_o   (b_o),
        .drv_o (drv_o)
    );

    pxc_parity_unit #(.W(W)) u_par (
        .ctl_i     (ctl_i),
        .gen_src_i (a_i),
        .chk_src_i (b_i),
        .par_i     (par_i),
        .par_o     (par_o),
        .err_n_o   (err_n_o)
    );

    always_comb begin
        if (!$isunknown({ctl_i, a_i, b_i})) begin
            if (drv_o.b_drv) begin
                assert_tx_copy_R2: assert (b_o == a_i) else $error("B side not a copy of A");
            end
            if (drv_o.a_drv) begin
                assert_rx_copy_R3: assert (a_o == b_i) else $error("A side not a copy of B");
            end
        end
    end

endmodule

// File: rtl/pxc_wide_xcvr.sv
module pxc_wide_xcvr
    import pxc_pkg::*;
#(
    parameter int SEC_W  = 8,
    parameter int N_SEC  = 2,
    localparam int BUS_W = SEC_W * N_SEC
) (
    input  logic [N_SEC-1:0] dir_i,
    input  logic [N_SEC-1:0] hiz_i,
    input  logic [N_SEC-1:0] odd_i,
    input  logic [BUS_W-1:0] a_i,
    output logic [BUS_W-1:0] a_o,
    output logic [N_SEC-1:0] a_oe,
    input  logic [BUS_W-1:0] b_i,
    output logic [BUS_W-1:0] b_o,
    output logic [N_SEC-1:0] b_oe,
    input  logic [N_SEC-1:0] par_i,
    output logic [N_SEC-1:0] par_o,
    output logic [N_SEC-1:0] par_oe,
    output logic [N_SEC-1:0] err_n_o
);
    generate
        for (genvar s = 0; s < N_SEC; s++) begin : g_sec
            sec_ctl_t ctl;
            drv_t     drv;

            always_comb begin
                ctl.hiz     = hiz_i[s];
                ctl.dir     = dir_e'(dir_i[s]);
                ctl.odd_sel = odd_i[s];
            end

            pxc_section #(.W(SEC_W)) u_sec (
                .ctl_i   (ctl),
                .a_i     (a_i[s*SEC_W +: SEC_W]),
                .b_i     (b_i[s*SEC_W +: SEC_W]),
                .par_i   (par_i[s]),
                .a_o     (a_o[s*SEC_W +: SEC_W]),
                .b_o     (b_o[s*SEC_W +: SEC_W]),
                .drv_o   (drv),
                .par_o   (par_o[s]),
                .err_n_o (err_n_o[s])
            );

            assign a_oe[s]   = drv.a_drv;
            assign b_oe[s]   = drv.b_drv;
            assign par_oe[s] = drv.p_drv;
        end
    endgenerate

endmodule

// File: tb/pxc_wide_xcvr_bench.sv
module pxc_wide_xcvr_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int N = 2;
    localparam int MAX_CYCLES = 5000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [N-1:0]   dir_i, hiz_i, odd_i, par_i;
    logic [N*W-1:0] a_i, b_i;
    logic [N*W-1:0] a_o, b_o;
    logic [N-1:0]   a_oe, b_oe, par_o, par_oe, err_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    pxc_wide_xcvr u_pxc_wide_xcvr (
        .dir_i(dir_i), .hiz_i(hiz_i), .odd_i(odd_i),
        .a_i(a_i), .a_o(a_o), .a_oe(a_oe),
        .b_i(b_i), .b_o(b_o), .b_oe(b_oe),
        .par_i(par_i), .par_o(par_o), .par_oe(par_oe),
        .err_n_o(err_n_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ones(input logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) n += int'(v[i]);
        return n;
    endfunction

    // Behavioural reference: compares every section against counted ones.
    task automatic compare_all();
        for (int s = 0; s < N; s++) begin
            logic [W-1:0] av, bv;
            logic exp_a_oe, exp_b_oe, exp_par, exp_err;
            int na, nb;
            av = a_i[s*W +: W];
            bv = b_i[s*W +: W];
            na = ones(av);
            nb = ones(bv);
            exp_a_oe = !hiz_i[s] && !dir_i[s];
            exp_b_oe = !hiz_i[s] && dir_i[s];
            exp_par  = odd_i[s] ? ((na % 2) == 0) : ((na % 2) == 1);
            if (exp_a_oe) exp_err = odd_i[s] ? ((nb + int'(par_i[s])) % 2 == 1)
                                             : ((nb + int'(par_i[s])) % 2 == 0);
            else          exp_err = 1'b1;
            check("R2 b_o copy", 32'(b_o[s*W +: W]), 32'(av));
            check("R3 a_o copy", 32'(a_o[s*W +: W]), 32'(bv));
            check("R4 a_oe",     32'(a_oe[s]), 32'(exp_a_oe));
            check("R4 b_oe",     32'(b_oe[s]), 32'(exp_b_oe));
            check("R5 par_o",    32'(par_o[s]), 32'(exp_par));
            check("R5 par_oe",   32'(par_oe[s]), 32'(exp_b_oe));
            check("R6 R7 err_n", 32'(err_n_o[s]), 32'(exp_err));
        end
    endtask

    task automatic apply(input logic [N-1:0] d, input logic [N-1:0] h, input logic [N-1:0] o,
                         input logic [N*W-1:0] a, input logic [N*W-1:0] b, input logic [N-1:0] p);
        @(negedge clk);
        dir_i = d; hiz_i = h; odd_i = o; a_i = a; b_i = b; par_i = p;
        #1;
    endtask

    initial begin
        dir_i = '0; hiz_i = '1; odd_i = '0; a_i = '0; b_i = '0; par_i = '0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        #1;
        // Idle state: everything undriven, flags inactive.
        check("R4 idle a_oe", 32'(a_oe), 32'h0);
        check("R4 idle b_oe", 32'(b_oe), 32'h0);
        check("R7 idle err_n", 32'(err_n_o), 32'h3);

        // R5 example: even sense, five ones on A, parity must be 1.
        apply(2'b01, 2'b00, 2'b00, 16'h001F, 16'h0000, 2'b00);
        check("R5 even five ones", 32'(par_o[0]), 32'h1);
        check("R2 tx drive", 32'({a_oe[0], b_oe[0]}), 32'h1);

        // R6 example: odd sense, parity in high, three ones on B -> error.
        apply(2'b00, 2'b00, 2'b01, 16'h0000, 16'h0007, 2'b01);
        check("R6 odd three ones err", 32'(err_n_o[0]), 32'h0);
        check("R3 rx drive", 32'({a_oe[0], b_oe[0]}), 32'h2);
        apply(2'b00, 2'b00, 2'b01, 16'h0000, 16'h0007, 2'b00);
        check("R6 odd three ones ok", 32'(err_n_o[0]), 32'h1);

        // R7: a bad word is ignored in transmit and while disabled.
        apply(2'b01, 2'b00, 2'b01, 16'h0000, 16'h0007, 2'b01);
        check("R7 tx err held", 32'(err_n_o[0]), 32'h1);
        apply(2'b00, 2'b01, 2'b01, 16'h0000, 16'h0007, 2'b01);
        check("R7 hiz err held", 32'(err_n_o[0]), 32'h1);
        check("R4 hiz par_oe", 32'(par_oe[0]), 32'h0);

        // R1: section 1 held still while section 0 is toggled.
        apply(2'b10, 2'b00, 2'b10, 16'hA500, 16'h3C00, 2'b00);
        begin
            logic [31:0] snap;
            snap = {a_o[15:8], b_o[15:8], 4'h0, a_oe[1], b_oe[1], par_o[1], par_oe[1], err_n_o[1]};
            for (int k = 0; k < 8; k++) begin
                apply({1'b1, k[0]}, {1'b0, k[1]}, {1'b1, k[2]},
                      {8'hA5, 8'(k * 37)}, {8'h3C, 8'(k * 91)}, {1'b0, k[0]});
                check("R1 section isolation",
                      {a_o[15:8], b_o[15:8], 4'h0, a_oe[1], b_oe[1], par_o[1], par_oe[1], err_n_o[1]},
                      snap);
            end
        end

        // R8 sweep: every control combination with random data, compared each cycle.
        for (int it = 0; it < 400; it++) begin
            logic [5:0] c;
            c = 6'(it % 64);
            apply(c[1:0], c[3:2], c[5:4], 16'($urandom), 16'($urandom), 2'($urandom));
            compare_all();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", MAX_CYCLES, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule